// File: doc/BRIEF.md
# Overlapping Slot-Mapped Bank Router

This block sits between a CPU-side request port and seven physical memory banks that together back the background storage region of a display engine. The region is cut into 32 equal slots. A small table holds, for every slot, a 7-bit mask of the banks that currently back it. Any number of banks may back the same slot at once. A write reaches every bank named by the mask, with the same data and byte enables. A read returns the bitwise OR of the words read from every named bank, or zero when the mask is empty.

The banks are not all the same size. Each bank takes its word offset from the low address bits that fit its own capacity. A small bank therefore repeats, or wraps, inside a slot, and a large bank shows the same storage through several slots. The mask table is written through a port of its own, and a new mask is used from the next access on. Read data comes back one cycle after the request. The OR is formed from the bank output registers, gated by a registered copy of the mask.

Geometry is set by `SLOT_LSB`, the log2 of the slot span in bytes. The full-size region uses 14. The default of 6 keeps the test RAMs small and keeps every size ratio: banks A to D hold 8 slots, bank E holds 4, and banks F and G hold 1. Addresses on the port are word addresses, so byte address = {req_addr, 2'b00}.

Top module: `slot_bank_router`

## Requirements
- R1: After reset every slot mask is zero and rsp_valid is low, so the first read returns zero.
- R2: The slot index is the byte-address field [SLOT_LSB+4:SLOT_LSB], which is word-address bits [SLOT_LSB+2:SLOT_LSB-2]. This gives 32 slots.
- R3: Bit k of a slot mask (k = 0..6) selects bank k. Banks 0 to 6 are called A to G.
- R4: Banks A to D take their offset from the low SLOT_LSB+3 byte-address bits, bank E from the low SLOT_LSB+2 bits, and banks F and G from the low SLOT_LSB bits. Higher bits are ignored by that bank, so it wraps.
- R5: A read returns the bitwise OR of the words of all banks selected for the slot. With an empty mask it returns zero.
- R6: A write stores the data into every selected bank. Banks not selected keep their contents.
- R7: Byte-enable bit i covers data bits [8i+7:8i], and the enables apply in the same way to every bank a write reaches.
- R8: A mask written with map_we is used by accesses from the next cycle on. An access in the same cycle as the table write uses the previous mask.
- R9: rsp_valid is high exactly in the cycle after a read request (req_valid with req_write low). Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | SLOT_LSB+3 | Word address inside the region |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| map_we | input | 1 | Slot mask table write strobe |
| map_slot | input | 5 | Slot whose mask is written |
| map_mask | input | 7 | New bank mask, bit k = bank k |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | OR of the selected banks' read words |

## Verification
On every cycle the assertions check the response timing of reads and writes, the zero result of a read whose slot had an empty mask, and that a table write is seen by the next access to that slot. The assertions also check that reset leaves the response idle. The OR of overlapping banks, the fan-out of writes, byte-lane masking and each bank's wrap depend on stored contents. Only the bench's scenarios show these, by comparing against a bench-side model of all seven banks. The directed cases alias a small bank through several slots, re-map a slot between writes so that stale banks are read back, and write the table in the same cycle as a read.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NBANK      = 7;
  localparam int SLOT_W     = 5;
  localparam int NSLOT      = 1 << SLOT_W;

  // Word-offset width of bank k, given log2 of slot span in bytes.
  function automatic int bank_word_w(input int k, input int slot_lsb);
    if (k < 4)       return slot_lsb + 1;
    else if (k == 4) return slot_lsb;
    else             return slot_lsb - 2;
  endfunction
endpackage

// File: rtl/slot_mask_table.sv
module slot_mask_table #(
  parameter int SLOT_W = 5,
  parameter int NBANK  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [NBANK-1:0]  wr_mask,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [NBANK-1:0]  rd_mask
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [NBANK-1:0] tbl [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) tbl[s] <= '0;
    end else if (wr_en) begin
      tbl[wr_slot] <= wr_mask;
    end
  end

  assign rd_mask = tbl[rd_slot];
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int WORD_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [WORD_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << WORD_W;
  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) rd_q <= mem[addr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/read_merge.sv
module read_merge #(
  parameter int NBANK  = 7,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] bank_rdata [NBANK],
  input  logic [NBANK-1:0]  sel,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    merged = '0;
    for (int k = 0; k < NBANK; k++) begin
      if (sel[k]) merged = merged | bank_rdata[k];
    end
  end
endmodule

// File: rtl/slot_bank_router.sv
module slot_bank_router #(
  parameter int SLOT_LSB = 6,
  parameter int DATA_W   = 32,
  localparam int AW      = SLOT_LSB + 3,
  localparam int BEW     = DATA_W / 8,
  localparam int SW      = router_pkg::SLOT_W,
  localparam int NB      = router_pkg::NBANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BEW-1:0]    req_be,
  input  logic              map_we,
  input  logic [SW-1:0]     map_slot,
  input  logic [NB-1:0]     map_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [SW-1:0]     req_slot;
  logic [NB-1:0]     cur_mask;
  logic [NB-1:0]     bank_en;
  logic [NB-1:0]     sel_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] bank_rdata [NB];

  // Slot field sits just above the slot span (word address).
  assign req_slot = req_addr[SLOT_LSB-2 +: SW];

  slot_mask_table #(.SLOT_W(SW), .NBANK(NB)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_we),
    .wr_slot (map_slot),
    .wr_mask (map_mask),
    .rd_slot (req_slot),
    .rd_mask (cur_mask)
  );

  assign bank_en = {NB{req_valid}} & cur_mask;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam int WW = router_pkg::bank_word_w(k, SLOT_LSB);
    bank_ram #(.WORD_W(WW), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .en    (bank_en[k]),
      .we    (req_write),
      .addr  (req_addr[WW-1:0]),
      .wdata (req_wdata),
      .be    (req_be),
      .rdata (bank_rdata[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid && !req_write;
      sel_q       <= (req_valid && !req_write) ? cur_mask : '0;
    end
  end

  read_merge #(.NBANK(NB), .DATA_W(DATA_W)) u_merge (
    .bank_rdata (bank_rdata),
    .sel        (sel_q),
    .merged     (rsp_data)
  );

  assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/slot_bank_router_chk.sv
module slot_bank_router_chk #(
  parameter int SLOT_LSB = 6,
  parameter int DATA_W   = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [SLOT_LSB+2:0]   req_addr,
  input logic                  map_we,
  input logic [4:0]            map_slot,
  input logic [6:0]            map_mask,
  input logic [6:0]            cur_mask,
  input logic                  rsp_valid,
  input logic [DATA_W-1:0]     rsp_data
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R9

  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid); // R9

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && cur_mask == '0) |=> (rsp_data == '0)); // R5

  AST_MASK_NEXT_ACCESS: assert property (@(posedge clk) disable iff (rst)
    map_we |=> ((req_addr[SLOT_LSB-2 +: 5] != $past(map_slot)) ||
                (cur_mask == $past(map_mask)))); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid); // R1
endmodule

bind slot_bank_router slot_bank_router_chk #(.SLOT_LSB(SLOT_LSB), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .map_we    (map_we),
  .map_slot  (map_slot),
  .map_mask  (map_mask),
  .cur_mask  (cur_mask),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/slot_bank_router_bench.sv
module slot_bank_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 6;
  localparam int AW = L + 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic [3:0]    req_be;
  logic          map_we;
  logic [4:0]    map_slot;
  logic [6:0]    map_mask;
  logic          rsp_valid;
  logic [31:0]   rsp_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mdl [7][128];
  logic [6:0]  mtab [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_bank_router u_slot_bank_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .map_we(map_we), .map_slot(map_slot), .map_mask(map_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R4: word-offset width of each bank
  function automatic int wbits(int k);
    if (k < 4) return L + 1;
    if (k == 4) return L;
    return L - 2;
  endfunction

  // R2: slot field of a word address
  function automatic int slot_of(logic [AW-1:0] a);
    return int'(a[L-2 +: 5]);
  endfunction

  function automatic int widx(int k, logic [AW-1:0] a);
    return int'(a) & ((1 << wbits(k)) - 1);
  endfunction

  function automatic logic [31:0] mdl_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < 7; k++)
      if (mtab[slot_of(a)][k]) r |= mdl[k][widx(k, a)];
    return r;
  endfunction

  task automatic mdl_write(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
    for (int k = 0; k < 7; k++)
      if (mtab[slot_of(a)][k])
        for (int b = 0; b < 4; b++)
          if (be[b]) mdl[k][widx(k, a)][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare at the following negedge.
  task automatic step(bit v, bit w, logic [AW-1:0] a, logic [31:0] d,
                      logic [3:0] be, bit mwe, logic [4:0] ms, logic [6:0] mm,
                      string tag);
    logic [31:0] exp;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    map_we = mwe; map_slot = ms; map_mask = mm;
    exp = mdl_read(a);
    if (v && w) mdl_write(a, d, be);
    if (mwe) mtab[ms] = mm;
    @(negedge clk);
    if (v && !w) begin
      chk({tag, " rsp_valid (R9)"}, {31'd0, rsp_valid}, 32'd1);
      chk(tag, rsp_data, exp);
    end else begin
      chk("R9 no response", {31'd0, rsp_valid}, 32'd0);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(1, 0, a, '0, '0, 0, '0, '0, tag);
  endtask
  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be, string tag);
    step(1, 1, a, d, be, 0, '0, '0, tag);
  endtask
  task automatic mp(int s, logic [6:0] m);
    step(0, 0, '0, '0, '0, 1, 5'(s), m, "R8 map");
  endtask

  function automatic logic [AW-1:0] wa(int slot, int off);
    return AW'((slot << (L - 2)) | off);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    map_we = 0; map_slot = '0; map_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 32; s++) mtab[s] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_0042);
    for (int k = 0; k < 7; k++) for (int i = 0; i < 128; i++) mdl[k][i] = '0;
    do_reset();
    // Zero all bank storage through full fan-out.
    for (int s = 0; s < 8; s++) mp(s, 7'h7f);
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < 16; o++) wr(wa(s, o), '0, 4'hf, "init");
    do_reset();

    // R1: reset state
    chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    rd(wa(0, 0), "R1 read after reset");
    rd(wa(31, 15), "R1 read last slot after reset");

    // R3 / R6: one bank at a time, distinct data
    for (int k = 0; k < 7; k++) begin
      mp(2, 7'(1 << k));
      wr(wa(2, 3), 32'hA000_0000 | k, 4'hf, "R3 single bank write");
    end
    for (int k = 0; k < 7; k++) begin
      mp(2, 7'(1 << k));
      rd(wa(2, 3), "R3 single bank read");
    end
    // R6: write via A only, B untouched
    mp(2, 7'h01);
    wr(wa(2, 3), 32'h1234_5678, 4'hf, "R6 write A");
    mp(2, 7'h02);
    rd(wa(2, 3), "R6 unmapped bank kept");
    // R5: OR of overlapping banks, then empty mask
    mp(2, 7'h7f);
    rd(wa(2, 3), "R5 OR of all");
    mp(2, 7'h00);
    rd(wa(2, 3), "R5 empty mask zero");
    // R6: fan-out, then each read alone
    mp(4, 7'h51);
    wr(wa(4, 7), 32'hCAFE_F00D, 4'hf, "R6 fan-out write");
    for (int k = 0; k < 7; k++) begin
      mp(4, 7'(1 << k));
      rd(wa(4, 7), "R6 fan-out readback");
    end
    // R7: byte lanes on several banks
    mp(5, 7'h33);
    wr(wa(5, 1), 32'hFFFF_FFFF, 4'hf, "R7 fill");
    wr(wa(5, 1), 32'h0000_0000, 4'b0101, "R7 partial");
    for (int k = 0; k < 7; k++) begin
      mp(5, 7'(1 << k));
      rd(wa(5, 1), "R7 byte lanes per bank");
    end
    // R4: F wraps every slot, E every 4, A every 8
    mp(6, 7'h20);
    wr(wa(6, 9), 32'h0F0F_0001, 4'hf, "R4 F write");
    mp(13, 7'h20);
    rd(wa(13, 9), "R4 F alias");
    mp(8, 7'h10);
    wr(wa(8, 2), 32'h0E0E_0002, 4'hf, "R4 E write");
    mp(12, 7'h10);
    rd(wa(12, 2), "R4 E alias");
    mp(9, 7'h01);
    wr(wa(9, 5), 32'h0A0A_0003, 4'hf, "R4 A write");
    mp(17, 7'h01);
    rd(wa(17, 5), "R4 A alias");
    // R2: adjacent slots are distinct
    mp(18, 7'h00);
    rd(wa(18, 5), "R2 neighbour slot");
    // R8: table write in same cycle as read uses old mask, next uses new
    step(1, 0, wa(17, 5), '0, '0, 1, 5'd17, 7'h00, "R8 same-cycle old mask");
    rd(wa(17, 5), "R8 next-cycle new mask");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 9));
      logic [AW-1:0] a = AW'($urandom);
      logic [6:0] m = ($urandom_range(0, 3) == 0) ? 7'h00 : 7'($urandom);
      if (op < 4)
        step(1, 0, a, '0, '0, op == 0, 5'($urandom), m, "R5 random read");
      else if (op < 8)
        step(1, 1, a, $urandom, 4'($urandom), 0, '0, '0, "R6 random write");
      else
        step(0, 0, '0, '0, '0, 1, 5'($urandom), m, "R8 random map");
    end
    step(0, 0, '0, '0, '0, 0, '0, '0, "idle");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule